// File: doc/BRIEF.md
# Squashed Pointer-Increment Undo Unit

This unit sits where instructions reach the execute end of a pipeline. It watches the heads of two in-order queues: a direct path and an indirect path. Each head entry carries a generation tag and an instruction-count tag. An entry from a flushed path has a stale generation, and the unit drops it. An entry from the live path moves on to execute once its instruction-count tag comes up.

Some flushed entries had already bumped a memory pointer through an auto-increment store issued upstream. The unit does not buffer speculative stores. Instead it repairs memory after the flush. It sends a single-lane masked write that puts back the pointer value minus one, modulo 4096. It mirrors that word into the instruction cache and the data cache, and it counts the two stores involved (the original one and the repair).

Top module: `squash_undo_unit`

## Requirements
- R1: A head entry is stale when its generation equals neither `stage_gen_i` nor `cur_gen_i`. A stale head is popped without being sent to execute. It is popped in the same cycle unless it has to wait for the store port (R5).
- R2: A head that is not stale is popped and sent to execute (`exe_valid_o`) only when its instruction-count tag equals `cur_icnt_i`. `exe_from_ind_o` is 0 for the direct queue and 1 for the indirect queue.
- R3: For a stale head with the auto-increment flag set, `st_data_o` equals (final pointer value − 1) mod 4096. A final value of 0 gives 4095.
- R4: The undo write targets line `ptr_addr >> 3`. `st_mask_o` has exactly one of its 8 bits set, namely bit `ptr_addr[2:0]`.
- R5: While the store port is not ready, a stale auto-increment head stays in its queue. If that head is in the direct queue, the indirect queue is not popped in that cycle either.
- R6: Each accepted undo write (`st_valid_o && st_ready_i`) adds 2 to the binary local counter and 2 to the global counter. The global counter is output in Gray code (b xor b>>1).
- R7: On each accepted undo write, both cache update strobes pulse. They carry the full pointer address and the undo data.
- R8: The direct queue has priority. If both heads need an undo, the direct one is written and the indirect head waits. If both heads match the instruction count, only the direct one goes to execute.
- R9: While reset is asserted, nothing is popped, no store is requested, and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_gen_i | input | 4 | Generation latched by the execute stage |
| cur_gen_i | input | 4 | Core's current generation |
| cur_icnt_i | input | 4 | Core's current instruction count |
| dq_valid_i | input | 1 | Direct queue head present |
| dq_gen_i | input | 4 | Direct head generation tag |
| dq_icnt_i | input | 4 | Direct head instruction-count tag |
| dq_autoinc_i | input | 1 | Direct head had a pointer increment stored upstream |
| dq_ptr_addr_i | input | 15 | Direct head pointer address |
| dq_final_i | input | 12 | Direct head incremented pointer value |
| dq_pop_o | output | 1 | Remove direct head |
| iq_valid_i | input | 1 | Indirect queue head present |
| iq_gen_i | input | 4 | Indirect head generation tag |
| iq_icnt_i | input | 4 | Indirect head instruction-count tag |
| iq_autoinc_i | input | 1 | Indirect head had a pointer increment stored upstream |
| iq_ptr_addr_i | input | 15 | Indirect head pointer address |
| iq_final_i | input | 12 | Indirect head incremented pointer value |
| iq_pop_o | output | 1 | Remove indirect head |
| exe_valid_o | output | 1 | A head is handed to execute this cycle |
| exe_from_ind_o | output | 1 | Source of the handed-over head (1 = indirect) |
| st_valid_o | output | 1 | Undo write request |
| st_ready_i | input | 1 | Store port accepts the request |
| st_line_o | output | 12 | Undo write line address |
| st_mask_o | output | 8 | Undo write lane mask |
| st_data_o | output | 12 | Undo write data |
| ic_upd_valid_o | output | 1 | Instruction cache update strobe |
| dc_upd_valid_o | output | 1 | Data cache update strobe |
| upd_addr_o | output | 15 | Cache update address |
| upd_data_o | output | 12 | Cache update data |
| loc_stores_o | output | 16 | Local store count (binary) |
| glb_stores_gray_o | output | 16 | Global store count (Gray code) |

## Verification
The random stimulus draws the tags from a small range, so that in a typical cycle the two heads mix stale, live-but-waiting and live-and-due entries. Store readiness and the auto-increment flags are drawn independently, which separates plain drops, undo writes, and stalls that freeze one queue or both. Directed cycles target cases the random mix rarely isolates. One puts both heads in need of an undo, which exposes the wrong priority. One sets a final pointer value of 0, which exposes a missing wrap. One holds the store port while only the indirect head needs it, which shows that the direct queue keeps moving. Counter values checked across many accepted and refused writes tell a step of 2 apart from a step of 1, and show whether refused writes are counted.

// File: rtl/undo_pkg.sv
package undo_pkg;

  typedef enum logic {SRC_DIR = 1'b0, SRC_IND = 1'b1} undo_src_e;

  // Pointer value before the upstream increment, kept to w bits.
  function automatic logic [31:0] undo_value(input logic [31:0] fin, input int w);
    logic [31:0] lim;
    lim = (32'd1 << w) - 32'd1;
    return (fin - 32'd1) & lim;
  endfunction

  // One lane bit chosen by the offset inside the line.
  function automatic logic [31:0] lane_onehot(input logic [31:0] ofs);
    return 32'd1 << ofs[4:0];
  endfunction

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int k = 30; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

endpackage

// File: rtl/undo_tag_check.sv
module undo_tag_check #(
  parameter int GEN_W  = 4,
  parameter int ICNT_W = 4
) (
  input  logic              valid_i,
  input  logic [GEN_W-1:0]  gen_i,
  input  logic [ICNT_W-1:0] icnt_i,
  input  logic [GEN_W-1:0]  stage_gen_i,
  input  logic [GEN_W-1:0]  cur_gen_i,
  input  logic [ICNT_W-1:0] cur_icnt_i,
  output logic              stale_o,
  output logic              due_o
);
  logic gen_known;
  assign gen_known = (gen_i == stage_gen_i) || (gen_i == cur_gen_i);
  assign stale_o   = valid_i && !gen_known;
  assign due_o     = valid_i && gen_known && (icnt_i == cur_icnt_i);
endmodule

// File: rtl/undo_arbiter.sv
module undo_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] stale_i,
  input  logic [1:0] due_i,
  input  logic [1:0] autoinc_i,
  input  logic       st_ready_i,
  output logic [1:0] pop_o,
  output logic       exe_valid_o,
  output logic       exe_from_ind_o,
  output logic       st_req_o,
  output logic       st_src_o,
  output logic       undo_fire_o
);
  import undo_pkg::*;

  logic [1:0] need_undo;
  logic       dir_hold;

  assign need_undo = stale_i & autoinc_i;
  assign dir_hold  = need_undo[SRC_DIR] && !st_ready_i;

  always_comb begin
    st_req_o       = rst_n && (|need_undo);
    st_src_o       = need_undo[SRC_DIR] ? SRC_DIR : SRC_IND;
    undo_fire_o    = st_req_o && st_ready_i;
    pop_o[SRC_DIR] = rst_n && (stale_i[SRC_DIR] ? (!autoinc_i[SRC_DIR] || st_ready_i)
                                                : due_i[SRC_DIR]);
    pop_o[SRC_IND] = rst_n && !dir_hold &&
                     (stale_i[SRC_IND] ? (!autoinc_i[SRC_IND] || (st_ready_i && !need_undo[SRC_DIR]))
                                       : (due_i[SRC_IND] && !due_i[SRC_DIR]));
    exe_valid_o    = rst_n && (due_i[SRC_DIR] || (due_i[SRC_IND] && !dir_hold));
    exe_from_ind_o = !due_i[SRC_DIR];
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (need_undo[SRC_DIR] && !st_ready_i) |-> (pop_o == 2'b00)); // R5
  AST_STALE_NOT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid_o |-> !stale_i[exe_from_ind_o]); // R1
  AST_EXE_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid_o |-> pop_o[exe_from_ind_o]); // R2
  AST_DIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    due_i[SRC_DIR] |-> (exe_valid_o && !exe_from_ind_o && !pop_o[SRC_IND] || exe_valid_o && !exe_from_ind_o)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (pop_o == 2'b00) && !st_req_o); // R9
endmodule

// File: rtl/undo_counters.sv
module undo_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             undo_fire_i,
  output logic [CNT_W-1:0] loc_o,
  output logic [CNT_W-1:0] glb_gray_o
);
  import undo_pkg::*;

  localparam logic [31:0] CNT_MASK = (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);

  logic [31:0] glb_bin_next;
  assign glb_bin_next = (gray_to_bin(32'(glb_gray_o)) + 32'd2) & CNT_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_o      <= '0;
      glb_gray_o <= '0;
    end else if (undo_fire_i) begin
      loc_o      <= loc_o + CNT_W'(2);
      glb_gray_o <= CNT_W'(bin_to_gray(glb_bin_next));
    end
  end

  AST_LOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    undo_fire_i |=> (loc_o == $past(loc_o) + CNT_W'(2))); // R6
  AST_LOC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !undo_fire_i |=> $stable(loc_o)); // R6
  AST_GLB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    undo_fire_i |=> (CNT_W'(gray_to_bin(32'(glb_gray_o))) ==
                     CNT_W'(gray_to_bin(32'($past(glb_gray_o))) + 32'd2))); // R6
endmodule

// File: rtl/squash_undo_unit.sv
module squash_undo_unit #(
  parameter int GEN_W  = 4,
  parameter int ICNT_W = 4,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 3,
  parameter int CNT_W  = 16,
  localparam int LANES  = 1 << OFS_W,
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GEN_W-1:0]  stage_gen_i,
  input  logic [GEN_W-1:0]  cur_gen_i,
  input  logic [ICNT_W-1:0] cur_icnt_i,
  input  logic              dq_valid_i,
  input  logic [GEN_W-1:0]  dq_gen_i,
  input  logic [ICNT_W-1:0] dq_icnt_i,
  input  logic              dq_autoinc_i,
  input  logic [ADDR_W-1:0] dq_ptr_addr_i,
  input  logic [DATA_W-1:0] dq_final_i,
  output logic              dq_pop_o,
  input  logic              iq_valid_i,
  input  logic [GEN_W-1:0]  iq_gen_i,
  input  logic [ICNT_W-1:0] iq_icnt_i,
  input  logic              iq_autoinc_i,
  input  logic [ADDR_W-1:0] iq_ptr_addr_i,
  input  logic [DATA_W-1:0] iq_final_i,
  output logic              iq_pop_o,
  output logic              exe_valid_o,
  output logic              exe_from_ind_o,
  output logic              st_valid_o,
  input  logic              st_ready_i,
  output logic [LINE_W-1:0] st_line_o,
  output logic [LANES-1:0]  st_mask_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              ic_upd_valid_o,
  output logic              dc_upd_valid_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [DATA_W-1:0] upd_data_o,
  output logic [CNT_W-1:0]  loc_stores_o,
  output logic [CNT_W-1:0]  glb_stores_gray_o
);
  import undo_pkg::*;

  localparam int NQ = 2;

  logic [NQ-1:0]             q_valid, q_autoinc, q_stale, q_due, q_pop;
  logic [NQ-1:0][GEN_W-1:0]  q_gen;
  logic [NQ-1:0][ICNT_W-1:0] q_icnt;
  logic [NQ-1:0][ADDR_W-1:0] q_addr;
  logic [NQ-1:0][DATA_W-1:0] q_final;

  assign q_valid   = {iq_valid_i, dq_valid_i};
  assign q_autoinc = {iq_autoinc_i, dq_autoinc_i};
  assign q_gen     = {iq_gen_i, dq_gen_i};
  assign q_icnt    = {iq_icnt_i, dq_icnt_i};
  assign q_addr    = {iq_ptr_addr_i, dq_ptr_addr_i};
  assign q_final   = {iq_final_i, dq_final_i};

  for (genvar q = 0; q < NQ; q++) begin : g_tag
    undo_tag_check #(.GEN_W(GEN_W), .ICNT_W(ICNT_W)) u_chk (
      .valid_i     (q_valid[q]),
      .gen_i       (q_gen[q]),
      .icnt_i      (q_icnt[q]),
      .stage_gen_i (stage_gen_i),
      .cur_gen_i   (cur_gen_i),
      .cur_icnt_i  (cur_icnt_i),
      .stale_o     (q_stale[q]),
      .due_o       (q_due[q])
    );
  end

  logic st_src, undo_fire;

  undo_arbiter u_arb (
    .clk            (clk),
    .rst_n          (rst_n),
    .stale_i        (q_stale),
    .due_i          (q_due),
    .autoinc_i      (q_autoinc),
    .st_ready_i     (st_ready_i),
    .pop_o          (q_pop),
    .exe_valid_o    (exe_valid_o),
    .exe_from_ind_o (exe_from_ind_o),
    .st_req_o       (st_valid_o),
    .st_src_o       (st_src),
    .undo_fire_o    (undo_fire)
  );

  assign dq_pop_o = q_pop[SRC_DIR];
  assign iq_pop_o = q_pop[SRC_IND];

  // Undo write datapath
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;

  assign sel_addr  = q_addr[st_src];
  assign sel_data  = DATA_W'(undo_value(32'(q_final[st_src]), DATA_W));
  assign st_line_o = sel_addr[ADDR_W-1:OFS_W];
  assign st_mask_o = LANES'(lane_onehot(32'(sel_addr[OFS_W-1:0])));
  assign st_data_o = sel_data;

  assign ic_upd_valid_o = undo_fire;
  assign dc_upd_valid_o = undo_fire;
  assign upd_addr_o     = sel_addr;
  assign upd_data_o     = sel_data;

  undo_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .undo_fire_i (undo_fire),
    .loc_o       (loc_stores_o),
    .glb_gray_o  (glb_stores_gray_o)
  );

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o |-> ($countones(st_mask_o) == 1)); // R4
  AST_UPD_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_upd_valid_o || dc_upd_valid_o) |-> (st_valid_o && st_ready_i)); // R7
  AST_STORE_FROM_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o |-> (q_stale[st_src] && q_autoinc[st_src])); // R3
endmodule

// File: tb/tb_squash_undo_unit.sv
module tb_squash_undo_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] sg, cg, ci;
  logic dv, da, iv, ia, rdy;
  logic [3:0] dg, di, ig, ii;
  logic [14:0] dadr, iadr;
  logic [11:0] dfin, ifin;
  logic dq_pop, iq_pop, exe_v, exe_ind, st_v, ic_u, dc_u;
  logic [11:0] st_line, st_data, upd_data;
  logic [7:0]  st_mask;
  logic [14:0] upd_addr;
  logic [15:0] loc_cnt, glb_gray;

  int checks = 0;
  int fails  = 0;
  int exp_loc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  squash_undo_unit dut (
    .clk(clk), .rst_n(rst_n), .stage_gen_i(sg), .cur_gen_i(cg), .cur_icnt_i(ci),
    .dq_valid_i(dv), .dq_gen_i(dg), .dq_icnt_i(di), .dq_autoinc_i(da),
    .dq_ptr_addr_i(dadr), .dq_final_i(dfin), .dq_pop_o(dq_pop),
    .iq_valid_i(iv), .iq_gen_i(ig), .iq_icnt_i(ii), .iq_autoinc_i(ia),
    .iq_ptr_addr_i(iadr), .iq_final_i(ifin), .iq_pop_o(iq_pop),
    .exe_valid_o(exe_v), .exe_from_ind_o(exe_ind),
    .st_valid_o(st_v), .st_ready_i(rdy), .st_line_o(st_line), .st_mask_o(st_mask),
    .st_data_o(st_data), .ic_upd_valid_o(ic_u), .dc_upd_valid_o(dc_u),
    .upd_addr_o(upd_addr), .upd_data_o(upd_data),
    .loc_stores_o(loc_cnt), .glb_stores_gray_o(glb_gray)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int gray_of(input int b);
    return (b % 65536) ^ ((b % 65536) / 2);
  endfunction

  function automatic bit is_fresh(input logic [3:0] g);
    return (g == sg) || (g == cg);
  endfunction

  // Expected behaviour, checked in the current cycle; returns 1 when an undo is accepted.
  task automatic check_cycle(output bit fire);
    bit ds, dm, is_, im, dneed, ineed, hold, e_dpop, e_ipop, e_exe, e_st;
    int a, f;
    ds = dv && !is_fresh(dg);
    dm = dv && is_fresh(dg) && (di == ci);
    is_ = iv && !is_fresh(ig);
    im = iv && is_fresh(ig) && (ii == ci);
    dneed = ds && da;
    ineed = is_ && ia;
    hold  = dneed && !rdy;
    e_st  = dneed || ineed;
    fire  = e_st && rdy;
    if (ds) e_dpop = !da || rdy; else e_dpop = dm;
    if (hold) e_ipop = 0;
    else if (is_) e_ipop = !ia || (rdy && !dneed);
    else e_ipop = im && !dm;
    e_exe = dm || (im && !hold);
    chk(ds ? "R1" : "R2", "dq_pop", int'(dq_pop), int'(e_dpop));
    chk(hold ? "R5" : "R1", "iq_pop", int'(iq_pop), int'(e_ipop));
    chk("R2", "exe_valid", int'(exe_v), int'(e_exe));
    if (e_exe) chk("R8", "exe_from_ind", int'(exe_ind), dm ? 0 : 1);
    chk("R5", "st_valid", int'(st_v), int'(e_st));
    chk("R7", "upd_strobes", int'({ic_u, dc_u}), fire ? 3 : 0);
    if (e_st) begin
      a = dneed ? int'(dadr) : int'(iadr);
      f = dneed ? int'(dfin) : int'(ifin);
      chk("R3", "st_data", int'(st_data), (f + 4095) % 4096);
      chk("R4", "st_line", int'(st_line), a / 8);
      chk("R4", "st_mask", int'(st_mask), 1 << (a % 8));
      if (fire) begin
        chk("R7", "upd_addr", int'(upd_addr), a);
        chk("R7", "upd_data", int'(upd_data), (f + 4095) % 4096);
      end
    end
    chk("R6", "loc_count", int'(loc_cnt), exp_loc % 65536);
    chk("R6", "glb_gray", int'(glb_gray), gray_of(exp_loc));
  endtask

  task automatic randomize_inputs();
    sg = 4'($urandom % 4); cg = 4'($urandom % 4); ci = 4'($urandom % 2);
    dv = 1'($urandom % 8 != 0); dg = 4'($urandom % 5); di = 4'($urandom % 2);
    da = 1'($urandom % 2); dadr = 15'($urandom); dfin = 12'($urandom % 6 == 0 ? 0 : $urandom);
    iv = 1'($urandom % 8 != 0); ig = 4'($urandom % 5); ii = 4'($urandom % 2);
    ia = 1'($urandom % 2); iadr = 15'($urandom); ifin = 12'($urandom);
    rdy = 1'($urandom % 3 != 0);
  endtask

  task automatic run_cycle();
    bit fire;
    #(CLK_PERIOD/4);
    check_cycle(fire);
    if (fire) exp_loc += 2;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    randomize_inputs();
    repeat (3) @(negedge clk);
    // R9: quiet during reset
    dv = 1; dg = 4'd9; da = 1; iv = 1; ig = 4'd9; ia = 1; rdy = 1; sg = 0; cg = 1;
    #(CLK_PERIOD/4);
    chk("R9", "reset_pops", int'({dq_pop, iq_pop}), 0);
    chk("R9", "reset_store", int'(st_v), 0);
    chk("R9", "reset_loc", int'(loc_cnt), 0);
    chk("R9", "reset_glb", int'(glb_gray), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: both heads need an undo, direct goes first; R3 wrap on direct final 0
    sg = 0; cg = 1; ci = 0;
    dv = 1; dg = 5; da = 1; dadr = 15'o12345; dfin = 12'd0;
    iv = 1; ig = 6; ia = 1; iadr = 15'o00017; ifin = 12'd100;
    rdy = 1;
    run_cycle();
    // R5: indirect-only undo with port busy, direct live head still goes to execute
    dv = 1; dg = 1; di = 0; da = 0;
    rdy = 0;
    run_cycle();
    // R5: direct stale undo blocked freezes both queues
    dv = 1; dg = 7; da = 1; iv = 1; ig = 0; ii = 0; ia = 0;
    run_cycle();
    // R8: both live and due
    dg = 0; di = 0; ig = 1; ii = 0; rdy = 1;
    run_cycle();
    // R2: live but not yet due
    dg = 0; di = 1; ig = 1; ii = 1;
    run_cycle();

    for (int n = 0; n < N_RAND; n++) begin
      randomize_inputs();
      run_cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule